// File: doc/BRIEF.md
# Mask-and-Latch Interrupt Controller

This block gathers 32 interrupt lines into a single request for a CPU. It holds two registers that software can reach. The first is an enable mask with one bit per line. The second is a pending-status register, also with one bit per line. The CPU request is raised when any line is both pending and enabled. Alongside the request, the block reports the number of the lowest pending, enabled line. A handler can therefore service lines from bit 0 upward and read the next candidate after each acknowledge.

The meaning of the status register is fixed at build time by the `MODE` parameter:

- **Live-level (0):** status simply mirrors the inputs, and writes to it are ignored.
- **Edge (1):** a rising edge on an input sets the bit. Writing a one clears the bit.
- **Latched-level (2):** a high input sets the bit, and the bit stays set after the input falls. Writing a zero clears the bit.

In edge mode, each input is compared with its value from the previous clock. That previous value is reset to zero, so an input that is already high when reset is released counts as an edge.

Top module: `irq_mask_latch`

## Requirements
- R1: The register port has a one-bit address: 0 selects the 32-bit mask and 1 selects the 32-bit status register. A write takes effect at the clock edge where `reg_we` is high. `reg_rdata` shows the selected register combinationally.
- R2: The mask reads back exactly the last value written to it, on every bit. A mask bit of 1 enables its line and 0 disables it.
- R3: The active-high synchronous reset clears the mask and the status register. After reset, `cpu_irq` and `lowest_vld` are low.
- R4: `cpu_irq` is a register that takes the OR of (status AND mask) at each clock edge. It therefore follows a change in status or mask one cycle later, and it stays low while the mask is zero.
- R5: `lowest_idx` is the number of the lowest set bit of (status AND mask), and `lowest_vld` is high exactly when that value is nonzero. Both are combinational.
- R6: In edge mode, a 0-to-1 change of an input, seen between two clock edges, sets the status bit at the second edge. An input held high does not set the bit again after it has been cleared.
- R7: In edge mode, writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new edge in the same cycle as a clearing write leaves the bit set.
- R8: In latched-level mode, a high input sets its status bit at each clock edge. The bit stays set after the input falls, until software clears it.
- R9: In latched-level mode, writing 0 to a status bit clears it and writing 1 leaves it unchanged. An input that is still high sets the bit again at the same edge as the write.
- R10: In live-level mode, the status read equals the current inputs, and status writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | Interrupt lines |
| reg_addr | input | 1 | 0 = mask, 1 = status |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |
| lowest_idx | output | 5 | Lowest pending, enabled line |
| lowest_vld | output | 1 | Some line is pending and enabled |

## Verification
The hardest case to reach is a status write that coincides with a fresh input edge, together with writes made while an input is held high. In those cycles the set and clear paths of one bit both act at the same edge. The bench changes `irq_in` at the same negative edge at which it drives a status write, so the new edge and the acknowledge land on one clock. It also holds a line high across several clearing writes. The three modes are built side by side and given identical stimulus, so each status semantic is checked against the same sequence of events.

// File: rtl/irq_mask_latch.sv
module irq_mask_latch #(
  parameter int MODE    = 1,
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_addr,
  input  logic               reg_we,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               cpu_irq,
  output logic [IDX_W-1:0]   lowest_idx,
  output logic               lowest_vld
);
  localparam int MODE_LIVE  = 0;
  localparam int MODE_EDGE  = 1;
  localparam int MODE_LATCH = 2;

  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] stat_rd;
  logic [N_LINES-1:0] pend;
  logic               irq_q;

  wire wr_mask = reg_we & ~reg_addr;
  wire wr_stat = reg_we &  reg_addr;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata;
  end

  generate
    if (MODE == MODE_LIVE) begin : g_live
      assign stat_rd = irq_in;
    end else begin : g_held
      logic [N_LINES-1:0] stat_q;
      logic [N_LINES-1:0] set_v;
      logic [N_LINES-1:0] keep_v;

      if (MODE == MODE_EDGE) begin : g_edge
        logic [N_LINES-1:0] prev_q;
        always_ff @(posedge clk) begin
          if (rst) prev_q <= '0;
          else     prev_q <= irq_in;
        end
        assign set_v  = irq_in & ~prev_q;
        assign keep_v = wr_stat ? ~reg_wdata : '1;
      end else begin : g_latch
        assign set_v  = irq_in;
        assign keep_v = wr_stat ? reg_wdata : '1;
      end

      always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & keep_v) | set_v;
      end
      assign stat_rd = stat_q;
    end
  endgenerate

  assign pend      = stat_rd & mask_q;
  assign reg_rdata = reg_addr ? stat_rd : mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end
  assign cpu_irq = irq_q;

  always_comb begin
    lowest_idx = '0;
    lowest_vld = 1'b0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        lowest_idx = i[IDX_W-1:0];
        lowest_vld = 1'b1;
      end
    end
  end
endmodule

module irq_mask_latch_chk #(
  parameter int MODE    = 1,
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_in,
  input logic               reg_addr,
  input logic               reg_we,
  input logic [N_LINES-1:0] reg_wdata,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] status,
  input logic               cpu_irq,
  input logic [IDX_W-1:0]   lowest_idx,
  input logic               lowest_vld
);
  wire [N_LINES-1:0] pend = status & mask;
  wire [N_LINES-1:0] below = (N_LINES'(1) << lowest_idx) - N_LINES'(1);

  AST_MASK_RESET: assert property (@(posedge clk) rst |=> (mask == '0)); // R3
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_addr) |=> (mask == $past(reg_wdata))); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && !reg_addr) |=> $stable(mask)); // R2
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == $past(|pend))); // R4
  AST_LOWEST_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    lowest_vld |-> (pend[lowest_idx] && ((pend & below) == '0))); // R5
  AST_NONE_PENDING: assert property (@(posedge clk) disable iff (rst)
    !lowest_vld |-> (pend == '0)); // R5

  generate
    if (MODE == 1) begin : g_edge_chk
      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr) |=> ((status & $past(status)) == $past(status))); // R7
    end else if (MODE == 2) begin : g_latch_chk
      AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr) |=> ((status & $past(status)) == $past(status))); // R8
      AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(irq_in) & ~status) == '0)); // R9
    end
  endgenerate
endmodule

bind irq_mask_latch irq_mask_latch_chk #(.MODE(MODE), .N_LINES(N_LINES)) chk_i (
  .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .mask(mask_q), .status(stat_rd), .cpu_irq(cpu_irq),
  .lowest_idx(lowest_idx), .lowest_vld(lowest_vld)
);

// File: tb/irq_mask_latch_tb_top.sv
`timescale 1ns/1ps
module irq_mask_latch_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] irq = '0;
  logic addr = 1'b0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;

  logic [31:0] rd_l, rd_e, rd_t;
  logic irq_l, irq_e, irq_t;
  logic [4:0] idx_l, idx_e, idx_t;
  logic vld_l, vld_e, vld_t;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_mask_latch #(.MODE(1)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rd_e), .cpu_irq(irq_e), .lowest_idx(idx_e), .lowest_vld(vld_e));
  irq_mask_latch #(.MODE(0)) dut_lvl_i (
    .clk(clk), .rst(rst), .irq_in(irq), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rd_l), .cpu_irq(irq_l), .lowest_idx(idx_l), .lowest_vld(vld_l));
  irq_mask_latch #(.MODE(2)) dut_lat_i (
    .clk(clk), .rst(rst), .irq_in(irq), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
    .reg_rdata(rd_t), .cpu_irq(irq_t), .lowest_idx(idx_t), .lowest_vld(vld_t));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic sel(input logic a);
    addr = a;
    #1;
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    sel(1'b0);
    chk("R3 mask live", rd_l, 0); chk("R3 mask edge", rd_e, 0); chk("R3 mask latch", rd_t, 0);
    sel(1'b1);
    chk("R3 stat edge", rd_e, 0); chk("R3 stat latch", rd_t, 0);
    chk("R3 irq", {29'd0, irq_l, irq_e, irq_t}, 0);
    chk("R3 vld", {29'd0, vld_l, vld_e, vld_t}, 0);

    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      v = (32'h1 << i) ^ (32'h9E3779B9 * (i + 1));
      wr(1'b0, v);
      sel(1'b0);
      chk("R2 mask readback live", rd_l, v);
      chk("R1 R2 mask readback edge", rd_e, v);
      chk("R2 mask readback latch", rd_t, v);
    end
    wr(1'b0, 32'hFFFF_FFFF);

    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      addr = 1'b1;
      irq = b;
      tick(); #1;
      chk("R6 edge sets", rd_e, b);
      chk("R8 latch sets", rd_t, b);
      chk("R10 live follows", rd_l, b);
      chk("R5 idx edge", {27'd0, idx_e}, i);
      chk("R5 vld latch", {31'd0, vld_t}, 1);
      chk("R4 irq not yet", {31'd0, irq_e}, 0);
      tick(); #1;
      chk("R4 irq raised", {29'd0, irq_l, irq_e, irq_t}, 3'b111);
      irq = '0;
      tick(); #1;
      chk("R6 edge holds", rd_e, b);
      chk("R8 latch holds after drop", rd_t, b);
      chk("R10 live drops", rd_l, 0);
      wr(1'b1, ~b); #1;
      chk("R7 edge zero keeps", rd_e, b);
      chk("R9 latch zero clears", rd_t, 0);
      wr(1'b1, b); #1;
      chk("R7 edge one clears", rd_e, 0);
      chk("R9 latch stays clear", rd_t, 0);
    end

    addr = 1'b1;
    irq = 32'h8;
    tick();
    wr(1'b1, 32'h8); #1;
    chk("R6 edge cleared while held", rd_e, 0);
    chk("R9 latch one keeps", rd_t, 32'h8);
    tick(); #1;
    chk("R6 held high no retrigger", rd_e, 0);
    wr(1'b1, 32'h0); #1;
    chk("R10 live write ignored", rd_l, 32'h8);
    chk("R9 latch reset by high input", rd_t, 32'h8);
    irq = '0;
    tick(); #1;
    chk("R8 latch sticky", rd_t, 32'h8);
    wr(1'b1, 32'h0); #1;
    chk("R9 latch cleared", rd_t, 0);

    irq = 32'h20;
    tick();
    irq = '0;
    tick();
    irq = 32'h20;
    wr(1'b1, 32'h20); #1;
    chk("R7 edge beats clear", rd_e, 32'h20);
    chk("R9 latch with input high", rd_t, 32'h20);
    irq = '0;
    tick();
    wr(1'b1, 32'h20);
    wr(1'b1, 32'h0); #1;
    chk("R7 edge cleaned", rd_e, 0);
    chk("R9 latch cleaned", rd_t, 0);

    for (int i = 0; i < 32; i++) begin
      irq = 32'hFFFF_FFFF << i;
      #1;
      chk("R5 idx by input", {27'd0, idx_l}, i);
      chk("R5 vld by input", {31'd0, vld_l}, 1);
    end
    irq = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) begin
      wr(1'b0, 32'hFFFF_FFFF << i); #1;
      chk("R5 idx by mask", {27'd0, idx_l}, i);
    end
    wr(1'b0, 32'h0); #1;
    chk("R5 vld masked off", {31'd0, vld_l}, 0);
    tick(); #1;
    chk("R4 irq masked off", {31'd0, irq_l}, 0);
    irq = '0;
    tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule